// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a fast functional clock into the serial clock waveform of an I2C controller. A prescaler divides the functional clock into an internal count tick, and two period words set how many ticks the clock line stays low and how many it stays high. Each period word carries two byte-wide values. The lower byte serves standard and fast operation and the first, master-code phase of a high-speed transfer. The upper byte serves the data phase of a high-speed transfer. A phase input tells the generator when the high-speed data phase has begun.

The block drives a release-style SCL level, where 1 means the line is let go, and watches the sensed line. Its high-phase count only begins once the line is actually seen high, so a target that holds the line low stretches the clock. A tick strobe and one-cycle pulses on every falling and rising SCL edge go to the data shifter and the start/stop logic that sit beside it. Software programs the prescaler and the period words while the block is disabled. Disabling the block releases the line and clears every counter.

Top module: `scl_timing_gen`

## Requirements
- R1: While a phase is counting, `tickStb` is high for one cycle out of every `prescale`+1 clock cycles; the first tick of a low phase falls `prescale`+1 cycles after that phase's first cycle.
- R2: A low phase holds `sclOut` at 0 for exactly (L+7)*(`prescale`+1) cycles and contains L+7 ticks, where L is the selected byte of `lowPeriod`.
- R3: A high phase holds `sclOut` at 1 for W+(H+5)*(`prescale`+1) cycles and contains H+5 ticks, where H is the selected byte of `highPeriod` and W is the number of cycles from release until `sclIn` is first sampled high (W=1 when the line follows at once).
- R4: With `hsMode`=0, bits 7:0 of each period word are used whatever the value of `hsPhase`.
- R5: With `hsMode`=1, bits 7:0 are used while `hsPhase`=0 and bits 15:8 are used while `hsPhase`=1.
- R6: The period byte is chosen when a phase begins; a change of `hsPhase` in the middle of a phase first affects the next phase.
- R7: While `sclOut` is released but `sclIn` reads low, no tick occurs and the high count does not advance.
- R8: While `enable`=0 (from the second cycle on), `sclOut` is 1 and `tickStb`, `sclFall` and `sclRise` are 0; the next enable starts a complete low phase.
- R9: `sclFall` is high for exactly the first cycle in which `sclOut` is 0 after being 1 while enabled.
- R10: `sclRise` is high for exactly the first cycle in which `sclOut` is 1 after a counted low phase.
- R11: After reset, `sclOut` is 1 and `tickStb`, `sclFall` and `sclRise` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Module enable; 0 releases SCL and clears all counters |
| hsMode | input | 1 | High-speed operation select |
| hsPhase | input | 1 | 1 once the high-speed data phase has begun |
| prescale | input | 8 | Functional clock divider minus one |
| lowPeriod | input | 16 | Low phase word: [7:0] standard/fast, [15:8] high-speed |
| highPeriod | input | 16 | High phase word: [7:0] standard/fast, [15:8] high-speed |
| sclIn | input | 1 | Sensed SCL line level |
| sclOut | output | 1 | SCL drive level, 1 = released |
| tickStb | output | 1 | Internal tick strobe |
| sclFall | output | 1 | One-cycle pulse on each SCL falling edge |
| sclRise | output | 1 | One-cycle pulse on each SCL release |

## Verification
The hardest situation to reach from the ports is a change of the high-speed phase input that lands between the start of a phase and its end. The period byte would then be taken from the new setting too early. The stimulus waits for a falling-edge pulse and flips the phase input one cycle later. The current low phase must then keep the old byte while the following high phase takes the new one. Clock stretching is driven by a line model that holds the sensed line low for a random number of cycles after each release. This lengthens the wait state before the high count starts.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } sclState_e;

  // Strobes from the control FSM to the counting datapath.
  typedef struct packed {
    logic holdAll;    // block disabled: clear everything, release line
    logic startLow;   // begin a low phase: drive line low, latch low target
    logic relScl;     // end of low phase: release the line
    logic startHigh;  // line sensed high: latch high target, start counting
    logic countEn;    // a phase is counting ticks
  } sclStrobes_t;

endpackage

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sclIn,
  input  logic        phaseEnd,
  output sclStrobes_t stb
);

  sclState_e state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    if (!enable) begin
      stb.holdAll = 1'b1;
      stateNxt    = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stb.startLow = 1'b1;
          stateNxt     = ST_LOW;
        end
        ST_LOW: begin
          stb.countEn = 1'b1;
          if (phaseEnd) begin
            stb.relScl = 1'b1;
            stateNxt   = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (sclIn) begin
            stb.startHigh = 1'b1;
            stateNxt      = ST_HIGH;
          end
        end
        ST_HIGH: begin
          stb.countEn = 1'b1;
          if (phaseEnd) begin
            stb.startLow = 1'b1;
            stateNxt     = ST_LOW;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !sclIn && enable) |=> (state == ST_WAIT));

  // R2
  low_to_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && phaseEnd && enable) |=> (state == ST_WAIT));

  // R8
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE));

endmodule

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int PS_W     = 8,
  parameter int PER_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  sclStrobes_t        stb,
  input  logic               hsSel,
  input  logic [PS_W-1:0]    prescale,
  input  logic [2*PER_W-1:0] lowPeriod,
  input  logic [2*PER_W-1:0] highPeriod,
  output logic               phaseEnd,
  output logic               tickStb,
  output logic               sclOut,
  output logic               sclFall,
  output logic               sclRise
);

  localparam int CNT_W = PER_W + 1;
  localparam logic [CNT_W-1:0] LOW_ADD  = CNT_W'(LOW_OFS - 1);
  localparam logic [CNT_W-1:0] HIGH_ADD = CNT_W'(HIGH_OFS - 1);

  logic [PS_W-1:0]  psCnt;
  logic [CNT_W-1:0] phCnt;
  logic [CNT_W-1:0] curTarget;
  logic [PER_W-1:0] lowSel, highSel;
  logic             psAtEnd, phAtEnd, phaseClr;

  // Byte lanes of the period words: lower lane for standard/fast and the
  // master-code phase, upper lane for the high-speed data phase.
  assign lowSel  = hsSel ? lowPeriod[2*PER_W-1:PER_W]  : lowPeriod[PER_W-1:0];
  assign highSel = hsSel ? highPeriod[2*PER_W-1:PER_W] : highPeriod[PER_W-1:0];

  assign psAtEnd  = (psCnt == prescale);
  assign phAtEnd  = (phCnt == curTarget);
  assign phaseEnd = psAtEnd && phAtEnd;
  assign tickStb  = stb.countEn && psAtEnd;
  assign phaseClr = stb.holdAll || stb.startLow || stb.relScl || stb.startHigh;

  // Prescaler: wraps after prescale+1 cycles, restarts at each phase edge.
  always_ff @(posedge clk) begin
    if (!rstN || phaseClr) psCnt <= '0;
    else if (stb.countEn)  psCnt <= psAtEnd ? '0 : psCnt + 1'b1;
  end

  // Tick counter within the current phase.
  always_ff @(posedge clk) begin
    if (!rstN || phaseClr) phCnt <= '0;
    else if (tickStb)      phCnt <= phCnt + 1'b1;
  end

  // Terminal count, taken once per phase so mid-phase mode changes wait.
  always_ff @(posedge clk) begin
    if (!rstN || stb.holdAll) curTarget <= '0;
    else if (stb.startLow)    curTarget <= CNT_W'(lowSel) + LOW_ADD;
    else if (stb.startHigh)   curTarget <= CNT_W'(highSel) + HIGH_ADD;
  end

  // Line level and edge pulses.
  always_ff @(posedge clk) begin
    if (!rstN || stb.holdAll) begin
      sclOut  <= 1'b1;
      sclFall <= 1'b0;
      sclRise <= 1'b0;
    end else begin
      sclFall <= stb.startLow;
      sclRise <= stb.relScl;
      if (stb.startLow)    sclOut <= 1'b0;
      else if (stb.relScl) sclOut <= 1'b1;
    end
  end

  // R9
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (!sclOut && $past(sclOut)));

  // R10
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> (sclOut && !$past(sclOut)));

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickStb && prescale != '0 && $stable(prescale)) |=> !tickStb);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.countEn |-> (phCnt <= curTarget));

  // R9
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sclFall, sclRise}));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int PS_W     = 8,
  parameter int PER_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               hsMode,
  input  logic               hsPhase,
  input  logic [PS_W-1:0]    prescale,
  input  logic [2*PER_W-1:0] lowPeriod,
  input  logic [2*PER_W-1:0] highPeriod,
  input  logic               sclIn,
  output logic               sclOut,
  output logic               tickStb,
  output logic               sclFall,
  output logic               sclRise
);

  sclStrobes_t stb;
  logic        phaseEnd;
  logic        hsSel;

  assign hsSel = hsMode && hsPhase;

  scl_gen_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .sclIn    (sclIn),
    .phaseEnd (phaseEnd),
    .stb      (stb)
  );

  scl_gen_datapath #(
    .PS_W     (PS_W),
    .PER_W    (PER_W),
    .LOW_OFS  (LOW_OFS),
    .HIGH_OFS (HIGH_OFS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hsSel      (hsSel),
    .prescale   (prescale),
    .lowPeriod  (lowPeriod),
    .highPeriod (highPeriod),
    .phaseEnd   (phaseEnd),
    .tickStb    (tickStb),
    .sclOut     (sclOut),
    .sclFall    (sclFall),
    .sclRise    (sclRise)
  );

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !tickStb && !sclFall && !sclRise));

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic        hsMode;
  logic        hsPhase;
  logic [7:0]  prescale;
  logic [15:0] lowPeriod;
  logic [15:0] highPeriod;
  logic        sclIn;
  logic        sclOut, tickStb, sclFall, sclRise;
  logic        holdLow;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Monitor state
  int    runLen, tickCnt, gap, expLen, expTicks, holdCnt, highsDone;
  bit    haveLow, haveHigh, enPrev, prevScl;
  int    stretchFixed;
  bit    randStretch;
  string reqTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Open-drain style line: the target may hold it low.
  assign sclIn = sclOut && !holdLow;

  scl_timing_gen dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .hsMode     (hsMode),
    .hsPhase    (hsPhase),
    .prescale   (prescale),
    .lowPeriod  (lowPeriod),
    .highPeriod (highPeriod),
    .sclIn      (sclIn),
    .sclOut     (sclOut),
    .tickStb    (tickStb),
    .sclFall    (sclFall),
    .sclRise    (sclRise)
  );

  function automatic int selByte(logic [15:0] w, logic m, logic p);
    return (m && p) ? int'(w[15:8]) : int'(w[7:0]);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle-level monitor and line model, evaluated away from the clock edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (!enable) begin
        if (!enPrev) begin
          chk(sclOut == 1'b1, "R8", "disabled sclOut", int'(sclOut), 1);
          chk(!tickStb && !sclFall && !sclRise, "R8", "disabled strobes",
              int'({tickStb, sclFall, sclRise}), 0);
        end
        haveLow = 0; haveHigh = 0; holdLow = 1'b0; holdCnt = 0;
      end else begin
        if (sclOut != prevScl) begin
          if (!sclOut) chk(sclFall, "R9", "fall pulse on edge", int'(sclFall), 1);
          else         chk(sclRise, "R10", "rise pulse on edge", int'(sclRise), 1);
        end else begin
          chk(!sclFall && !sclRise, "R9", "pulse without edge",
              int'({sclFall, sclRise}), 0);
        end
        if (sclFall) begin
          if (haveHigh) begin
            chk(runLen == expLen, {"R3 ", reqTag}, "high length", runLen, expLen);
            chk(tickCnt == expTicks, {"R3 ", reqTag}, "high ticks", tickCnt, expTicks);
            highsDone++;
          end
          expTicks = selByte(lowPeriod, hsMode, hsPhase) + 7;
          expLen   = expTicks * (int'(prescale) + 1);
          runLen = 1; tickCnt = int'(tickStb); gap = 1;
          haveLow = 1; haveHigh = 0;
        end else if (sclRise) begin
          if (haveLow) begin
            chk(runLen == expLen, {"R2 ", reqTag}, "low length", runLen, expLen);
            chk(tickCnt == expTicks, {"R2 ", reqTag}, "low ticks", tickCnt, expTicks);
          end
          holdCnt = randStretch ? int'($urandom % 5) : stretchFixed;
          holdLow = (holdCnt > 0);
          expTicks = selByte(highPeriod, hsMode, hsPhase) + 5;
          expLen   = holdCnt + 1 + expTicks * (int'(prescale) + 1);
          runLen = 1; tickCnt = int'(tickStb);
          haveHigh = haveLow; haveLow = 0;
        end else begin
          runLen++; tickCnt += int'(tickStb); gap++;
          if (holdLow) begin
            chk(!tickStb, "R7", "tick while line held low", int'(tickStb), 0);
            holdCnt--;
            if (holdCnt == 0) holdLow = 1'b0;
          end
        end
        if (!sclOut && tickStb && haveLow) begin
          chk(gap == int'(prescale) + 1, "R1", "tick spacing", gap, int'(prescale) + 1);
          gap = 0;
        end
      end
    end
    enPrev  = enable;
    prevScl = sclOut;
  end

  task automatic setCfg(int p, logic [15:0] lw, logic [15:0] hw, bit m, bit ph);
    @(posedge clk); #2 enable = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    prescale = 8'(p); lowPeriod = lw; highPeriod = hw; hsMode = m; hsPhase = ph;
    @(posedge clk); #2 enable = 1'b1;
  endtask

  task automatic waitHighs(int n);
    int target;
    target = highsDone + n;
    while (highsDone < target && !finished) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; enable = 1'b0; hsMode = 1'b0; hsPhase = 1'b0;
    prescale = '0; lowPeriod = '0; highPeriod = '0; holdLow = 1'b0;
    randStretch = 1'b0; stretchFixed = 0; reqTag = "R4"; highsDone = 0;
    haveLow = 0; haveHigh = 0; enPrev = 0; prevScl = 1; holdCnt = 0;
    runLen = 0; tickCnt = 0; gap = 0; expLen = 0; expTicks = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(sclOut == 1'b1, "R11", "reset sclOut", int'(sclOut), 1);
    chk(!tickStb && !sclFall && !sclRise, "R11", "reset strobes",
        int'({tickStb, sclFall, sclRise}), 0);

    // R4: smallest periods, no prescale, standard mode, hsPhase ignored
    reqTag = "R4";
    setCfg(0, 16'h0000, 16'h0000, 1'b0, 1'b0); waitHighs(3);
    setCfg(2, 16'h0903, 16'h0801, 1'b0, 1'b1); waitHighs(3);

    // R5: high-speed mode, master-code phase then data phase
    reqTag = "R5";
    setCfg(1, 16'h0502, 16'h0403, 1'b1, 1'b0); waitHighs(2);
    setCfg(1, 16'h0502, 16'h0403, 1'b1, 1'b1); waitHighs(2);

    // R6: phase input flips in the middle of a low phase
    reqTag = "R6";
    setCfg(1, 16'h0601, 16'h0402, 1'b1, 1'b0); waitHighs(1);
    @(negedge clk); while (!sclFall) @(negedge clk);
    @(posedge clk); #2 hsPhase = 1'b1;
    waitHighs(2);

    // R7: fixed long stretch by the target
    reqTag = "R7";
    stretchFixed = 6;
    setCfg(1, 16'h0002, 16'h0001, 1'b0, 1'b0); waitHighs(3);
    stretchFixed = 0;

    // R8: disable in the middle of a low phase, then restart
    reqTag = "R8";
    @(negedge clk); while (!sclFall) @(negedge clk);
    repeat (3) @(posedge clk);
    #2 enable = 1'b0;
    repeat (6) @(posedge clk);
    #2 enable = 1'b1;
    waitHighs(2);

    // Random configurations with random stretching
    reqTag = "R2 R3 random";
    randStretch = 1'b1;
    for (int i = 0; i < 12; i++) begin
      setCfg(int'($urandom % 4),
             {8'($urandom % 6), 8'($urandom % 6)},
             {8'($urandom % 6), 8'($urandom % 6)},
             1'($urandom % 2), 1'($urandom % 2));
      waitHighs(3);
    end
    randStretch = 1'b0;

    @(posedge clk); #2 enable = 1'b0;
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule